// File: doc/BRIEF.md
# Page-Tracking Next-Line L1 Prefetcher

This block sits beside an L1 data cache and watches the stream of loads, software prefetches and stores that reach it. It remembers up to four recently touched physical 4 KB pages in a small fully associative table. It also keeps a 2-bit counter for every cache set. Each counted access to a set bumps that set's counter. On the third counted access the counter clears and the block fans out a burst of next-line prefetches: one for every tracked page that has not been written, each aimed at the line that follows the triggering set inside that page.

The table refuses to track traffic the prefetcher must not touch. Pages that have seen a store stay out of both counting and prefetching. Accesses that are not of the write-back memory type are ignored. A prefetch never crosses the page boundary. The burst leaves the block one request at a time on a valid/ready port. It waits while a fence is in progress and silently drops a request when no fill buffer is free. A TLB flush empties the page table.

Top module: `pgtrack_prefetcher`

## Requirements
- R1: After reset, pf_valid is low and no page is tracked, so the first burst after reset names only pages touched since reset.
- R2: Each set (address bits [11:6]) has a 2-bit counter. The counter advances on a write-back load (acc_kind 2'b00) or software prefetch (acc_kind 2'b01) to a page that has not been written. The third such access triggers a burst and returns the counter to zero. Kinds 2'b10 and 2'b11 do nothing.
- R3: A burst issues one request per tracked, unwritten page, in ascending table-entry order. Each request is {page number, set+1, six zero bits}. Byte offset bits [5:0] of the triggering accesses play no part.
- R4: The table has 4 entries. A load, software prefetch or store to an untracked page fills the lowest-numbered free entry. When no entry is free, it replaces the least recently touched one. Every tracked access counts as a touch.
- R5: A store (acc_store=1) marks its page written, allocating it if needed. A written page neither advances counters nor receives prefetches.
- R6: Only acc_mtype 3'b110 (write-back) is tracked. Every other code leaves the table and counters untouched.
- R7: A trigger on set 63 produces no request, because the next line would lie outside the page.
- R8: No request is raised while fence_busy is high. Pending requests of a burst wait and go out after the fence clears.
- R9: When fb_free is zero at the moment a request would be raised, that request is dropped and never retried.
- R10: tlb_flush clears every valid and written flag. An access presented in the same cycle is ignored.
- R11: While pf_valid is high and pf_ready low, pf_valid and pf_addr hold. A trigger that occurs while a burst is still in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 40 | Physical byte address of the access |
| acc_kind | input | 2 | 00 demand load, 01 software prefetch, others ignored |
| acc_mtype | input | 3 | Memory-type code, 110 is write-back |
| acc_store | input | 1 | Access is a store |
| fence_busy | input | 1 | A fence is in progress in the pipeline |
| fb_free | input | 4 | Number of free fill buffers (0 to 10) |
| tlb_flush | input | 1 | Clear the page table |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | 40 | Line address of the offered prefetch |
| pf_ready | input | 1 | The consumer takes the offered request |

## Verification
The assertions assume the consumer follows valid/ready. They also assume that fence_busy and fb_free are meaningful in the cycle before a request is raised, because that is where the block makes its decision. The bench drives every input only on falling edges and holds fb_free and fence_busy steady across each burst. It leaves enough idle cycles after each triggering access for the burst to drain, except in the one scenario that deliberately overlaps two triggers. As a result, the bench's page-table model always matches the snapshot the block takes.

// File: rtl/pf_pkg.sv
// Shared codes and types for the page-tracking next-line prefetcher.
// Assumes: memory-type and access-kind encodings are fixed by the load pipeline.
package pf_pkg;
    localparam logic [2:0] MT_WRITEBACK = 3'b110;
    localparam logic [1:0] AK_LOAD      = 2'b00;
    localparam logic [1:0] AK_SWPF      = 2'b01;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_SCAN,
        BS_SEND
    } burst_state_e;
endpackage

// File: rtl/pf_page_table.sv
// Fully associative table of recently touched physical pages with a
// written flag per entry and rank-based LRU replacement.
// Assumes: upd_en is already qualified (write-back, counted kind or store,
// no flush in the same cycle); flush wins over any update.
module pf_page_table #(
    parameter int PPN_W   = 28,
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic               upd_store,
    input  logic [PPN_W-1:0]   upd_ppn,
    input  logic               flush,
    output logic               page_clean,
    output logic [ENTRIES-1:0] ent_valid,
    output logic [ENTRIES-1:0] ent_wr,
    output logic [PPN_W-1:0]   ent_ppn [ENTRIES]
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [IDX_W-1:0]   rank [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic               free_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   lru_idx;
    logic [IDX_W-1:0]   tgt_idx;

    // Tag compare for each entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g] && (ent_ppn[g] == upd_ppn);
    end

    // Choose the entry an update lands in: hit, lowest free, else LRU.
    always_comb begin
        hit_any  = |hit_vec;
        free_any = ~&ent_valid;
        hit_idx  = '0;
        free_idx = '0;
        lru_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i])                           hit_idx  = IDX_W'(i);
            if (!ent_valid[i])                        free_idx = IDX_W'(i);
            if (rank[i] == IDX_W'(ENTRIES - 1))       lru_idx  = IDX_W'(i);
        end
        tgt_idx    = hit_any ? hit_idx : (free_any ? free_idx : lru_idx);
        page_clean = hit_any ? !ent_wr[hit_idx] : 1'b1;
    end

    // Entry contents: flush clears flags, an update writes the target entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_wr    <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_ppn[i] <= '0;
        end else if (flush) begin
            ent_valid <= '0;
            ent_wr    <= '0;
        end else if (upd_en) begin
            ent_valid[tgt_idx] <= 1'b1;
            ent_ppn[tgt_idx]   <= upd_ppn;
            ent_wr[tgt_idx]    <= (hit_any && ent_wr[tgt_idx]) || upd_store;
        end
    end

    // Recency ranks: touched entry becomes 0, younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank[i] <= IDX_W'(i);
        end else if (upd_en && !flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == tgt_idx)         rank[i] <= '0;
                else if (rank[i] < rank[tgt_idx]) rank[i] <= rank[i] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pf_set_counters.sv
// One small counter per cache set; the access that would bring a counter
// to its top value instead clears it and emits a one-cycle trigger.
// Assumes: bump is asserted only for counted accesses to clean pages.
module pf_set_counters #(
    parameter int SET_W = 6,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic [SET_W-1:0] bump_set,
    output logic             trig,
    output logic [SET_W-1:0] trig_set
);
    localparam int SETS    = 1 << SET_W;
    localparam int CNT_TOP = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt [SETS];

    // Advance the addressed counter and raise the trigger on saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) cnt[i] <= '0;
            trig     <= 1'b0;
            trig_set <= '0;
        end else begin
            trig <= 1'b0;
            if (bump) begin
                if (cnt[bump_set] == CNT_W'(CNT_TOP - 1)) begin
                    cnt[bump_set] <= '0;
                    trig          <= 1'b1;
                    trig_set      <= bump_set;
                end else begin
                    cnt[bump_set] <= cnt[bump_set] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pf_burst_issuer.sv
// Snapshots the page table on a trigger and walks its entries in index
// order, offering one next-line request at a time on a valid/ready port.
// Assumes: triggers arriving while a walk is in progress may be lost;
// fence and fill-buffer state are judged in the cycle before raising valid.
module pf_burst_issuer #(
    parameter int PPN_W     = 28,
    parameter int SET_W     = 6,
    parameter int LINE_BITS = 6,
    parameter int ENTRIES   = 4,
    parameter int FB_W      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic [SET_W-1:0]   trig_set,
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] ent_wr,
    input  logic [PPN_W-1:0]   ent_ppn [ENTRIES],
    input  logic               fence_busy,
    input  logic [FB_W-1:0]    fb_free,
    input  logic               pf_ready,
    output logic               pf_valid,
    output logic [PPN_W+SET_W+LINE_BITS-1:0] pf_addr
);
    import pf_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    burst_state_e       st;
    logic [IDX_W-1:0]   ptr;
    logic [ENTRIES-1:0] go;
    logic [SET_W-1:0]   line;
    logic [PPN_W-1:0]   snap_ppn [ENTRIES];
    logic               launch;
    logic               step;
    logic               at_last;

    // Decide whether the current entry is sent, skipped, dropped or waits.
    always_comb begin
        at_last = (ptr == IDX_W'(ENTRIES - 1));
        launch  = (st == BS_SCAN) && go[ptr] && !fence_busy && (fb_free != '0);
        step    = ((st == BS_SCAN) && (!go[ptr] || (!fence_busy && fb_free == '0)))
               || ((st == BS_SEND) && pf_ready);
    end

    // Burst walk state, snapshot and request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BS_IDLE;
            ptr     <= '0;
            go      <= '0;
            line    <= '0;
            pf_addr <= '0;
            for (int i = 0; i < ENTRIES; i++) snap_ppn[i] <= '0;
        end else begin
            if (st == BS_IDLE) begin
                if (trig) begin
                    for (int i = 0; i < ENTRIES; i++) snap_ppn[i] <= ent_ppn[i];
                    go   <= ent_valid & ~ent_wr & {ENTRIES{~&trig_set}};
                    line <= trig_set + 1'b1;
                    ptr  <= '0;
                    st   <= BS_SCAN;
                end
            end else if (launch) begin
                pf_addr <= {snap_ppn[ptr], line, {LINE_BITS{1'b0}}};
                st      <= BS_SEND;
            end else if (step) begin
                if (at_last) begin
                    st <= BS_IDLE;
                end else begin
                    ptr <= ptr + 1'b1;
                    st  <= BS_SCAN;
                end
            end
        end
    end

    assign pf_valid = (st == BS_SEND);
endmodule

// File: rtl/pgtrack_prefetcher.sv
// Top of the page-tracking next-line prefetcher: qualifies each access,
// updates the page table and set counters, and drives the request port.
// Assumes: one access per cycle; byte offset within a line is irrelevant;
// a page is 2**PAGE_BITS bytes and holds exactly one line per set.
module pgtrack_prefetcher #(
    parameter int ADDR_W    = 40,
    parameter int PAGE_BITS = 12,
    parameter int LINE_BITS = 6,
    parameter int ENTRIES   = 4,
    parameter int CNT_W     = 2,
    parameter int FB_TOTAL  = 10
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc_valid,
    input  logic [ADDR_W-1:0]                acc_addr,
    input  logic [1:0]                       acc_kind,
    input  logic [2:0]                       acc_mtype,
    input  logic                             acc_store,
    input  logic                             fence_busy,
    input  logic [$clog2(FB_TOTAL+1)-1:0]    fb_free,
    input  logic                             tlb_flush,
    output logic                             pf_valid,
    output logic [ADDR_W-1:0]                pf_addr,
    input  logic                             pf_ready
);
    import pf_pkg::*;

    localparam int PPN_W = ADDR_W - PAGE_BITS;
    localparam int SET_W = PAGE_BITS - LINE_BITS;
    localparam int FB_W  = $clog2(FB_TOTAL + 1);

    logic [PPN_W-1:0]   acc_ppn;
    logic [SET_W-1:0]   acc_set;
    logic               tracked;
    logic               bump;
    logic               page_clean;
    logic               trig;
    logic [SET_W-1:0]   trig_set;
    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_wr;
    logic [PPN_W-1:0]   ent_ppn [ENTRIES];
    logic               unused_line_offset;

    // Split the address and qualify the access.
    always_comb begin
        acc_ppn = acc_addr[ADDR_W-1:PAGE_BITS];
        acc_set = acc_addr[PAGE_BITS-1:LINE_BITS];
        tracked = acc_valid && !tlb_flush && (acc_mtype == MT_WRITEBACK)
               && (acc_store || acc_kind == AK_LOAD || acc_kind == AK_SWPF);
        bump    = tracked && !acc_store && page_clean;
    end

    assign unused_line_offset = ^acc_addr[LINE_BITS-1:0];

    pf_page_table #(
        .PPN_W   (PPN_W),
        .ENTRIES (ENTRIES)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (tracked),
        .upd_store  (acc_store),
        .upd_ppn    (acc_ppn),
        .flush      (tlb_flush),
        .page_clean (page_clean),
        .ent_valid  (ent_valid),
        .ent_wr     (ent_wr),
        .ent_ppn    (ent_ppn)
    );

    pf_set_counters #(
        .SET_W (SET_W),
        .CNT_W (CNT_W)
    ) u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .bump     (bump),
        .bump_set (acc_set),
        .trig     (trig),
        .trig_set (trig_set)
    );

    pf_burst_issuer #(
        .PPN_W     (PPN_W),
        .SET_W     (SET_W),
        .LINE_BITS (LINE_BITS),
        .ENTRIES   (ENTRIES),
        .FB_W      (FB_W)
    ) u_issuer (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .trig_set   (trig_set),
        .ent_valid  (ent_valid),
        .ent_wr     (ent_wr),
        .ent_ppn    (ent_ppn),
        .fence_busy (fence_busy),
        .fb_free    (fb_free),
        .pf_ready   (pf_ready),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr)
    );
endmodule

// File: rtl/pf_prefetch_checker.sv
// Protocol and placement properties of the prefetch request port.
// Assumes: consumer follows valid/ready; reset is synchronous active-low.
module pf_prefetch_checker #(
    parameter int ADDR_W    = 40,
    parameter int PAGE_BITS = 12,
    parameter int LINE_BITS = 6,
    parameter int FB_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fence_busy,
    input logic [FB_W-1:0]   fb_free,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr
);
    AST_PF_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[LINE_BITS-1:0] == '0)); // R3

    AST_PF_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[PAGE_BITS-1:LINE_BITS] != '0)); // R7

    AST_PF_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R11

    AST_NO_RAISE_IN_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> !$past(fence_busy)); // R8

    AST_RAISE_NEEDS_FILL_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> ($past(fb_free) != '0)); // R9
endmodule

bind pgtrack_prefetcher pf_prefetch_checker #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .LINE_BITS (LINE_BITS),
    .FB_W      ($clog2(FB_TOTAL + 1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fence_busy (fence_busy),
    .fb_free    (fb_free),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr)
);

// File: tb/pgtrack_prefetcher_tb.sv
// Self-checking bench: a behavioural page-table/counter model predicts each
// burst; a monitor compares every handshake against the predicted list.
module pgtrack_prefetcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [39:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  acc_mtype = '0;
    logic        acc_store = 1'b0;
    logic        fence_busy = 1'b0;
    logic [3:0]  fb_free = 4'd10;
    logic        tlb_flush = 1'b0;
    logic        pf_valid;
    logic [39:0] pf_addr;
    logic        pf_ready = 1'b1;

    always #5 clk = ~clk;

    pgtrack_prefetcher u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .acc_mtype(acc_mtype), .acc_store(acc_store),
        .fence_busy(fence_busy), .fb_free(fb_free), .tlb_flush(tlb_flush),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
    );

    int checks = 0;
    int fails  = 0;
    int hs_cnt = 0;
    bit seen_valid = 0;

    // Model state
    bit          m_v [4];
    bit          m_w [4];
    logic [27:0] m_ppn [4];
    int          m_st [4];
    int          m_cnt [64];
    int          tnow = 0;
    bit          suppress = 0;
    bit          drop_fb = 0;
    logic [39:0] exp_a [0:511];
    int          qh = 0;
    int          qt = 0;

    function automatic logic [39:0] mk(input logic [27:0] p, input int s, input int off);
        return {p, 6'(s), 6'(off)};
    endfunction

    task automatic fail_line(input string req, input logic [39:0] act, input logic [39:0] exp);
        fails++;
        $display("FAIL %s actual=%h expected=%h", req, act, exp);
    endtask

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) fail_line(req, act, exp);
    endtask

    // Reference model of one access (or a flush)
    task automatic model(input logic [39:0] a, input logic [1:0] k, input logic [2:0] mt,
                         input bit st, input bit fl);
        int idx;
        int hit;
        bit clean;
        int s;
        if (fl) begin
            for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_w[i] = 0; end
            return;
        end
        if (mt != 3'b110) return;
        if (!st && k > 2'd1) return;
        s = int'(a[11:6]);
        hit = -1;
        for (int i = 0; i < 4; i++) if (m_v[i] && m_ppn[i] == a[39:12]) hit = i;
        if (hit < 0) begin
            idx = -1;
            for (int i = 3; i >= 0; i--) if (!m_v[i]) idx = i;
            if (idx < 0) begin
                idx = 0;
                for (int i = 1; i < 4; i++) if (m_st[i] < m_st[idx]) idx = i;
            end
            m_v[idx] = 1; m_ppn[idx] = a[39:12]; m_w[idx] = st; clean = 1;
        end else begin
            idx = hit; clean = !m_w[idx]; m_w[idx] = m_w[idx] | st;
        end
        tnow++;
        m_st[idx] = tnow;
        if (st || !clean) return;
        if (m_cnt[s] == 2) begin
            m_cnt[s] = 0;
            if (!suppress && !drop_fb && s != 63)
                for (int i = 0; i < 4; i++)
                    if (m_v[i] && !m_w[i]) begin
                        exp_a[qt] = mk(m_ppn[i], s + 1, 0);
                        qt++;
                    end
        end else begin
            m_cnt[s]++;
        end
    endtask

    task automatic acc(input logic [39:0] a, input logic [1:0] k, input logic [2:0] mt,
                       input bit st, input int gap);
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_kind = k; acc_mtype = mt; acc_store = st;
        @(negedge clk);
        acc_valid = 0; acc_store = 0;
        model(a, k, mt, st, 0);
        repeat (gap) @(negedge clk);
    endtask

    task automatic flush_with(input logic [39:0] a);
        @(negedge clk);
        tlb_flush = 1; acc_valid = 1; acc_addr = a; acc_kind = 2'b00; acc_mtype = 3'b110;
        @(negedge clk);
        tlb_flush = 0; acc_valid = 0;
        model(a, 2'b00, 3'b110, 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic drained(input string req);
        checks++;
        if (qh != qt) fail_line(req, 40'(qh), 40'(qt));
    endtask

    // Monitor: compare each handshake with the predicted order (R3)
    always @(negedge clk) begin
        if (rst_n && pf_valid) seen_valid <= 1;
        if (rst_n && pf_valid && pf_ready) begin
            hs_cnt++;
            checks++;
            if (qh >= qt) fail_line("R3 unexpected prefetch", pf_addr, 40'h0);
            else begin
                if (pf_addr !== exp_a[qh]) fail_line("R3 prefetch address", pf_addr, exp_a[qh]);
                qh++;
            end
        end
    end

    // Watchdog
    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", hs_cnt);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    localparam logic [2:0] WB = 3'b110;
    int base;

    initial begin
        for (int i = 0; i < 64; i++) m_cnt[i] = 0;
        for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_w[i] = 0; m_st[i] = 0; m_ppn[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pf_valid after reset", 40'(pf_valid), 40'h0);

        // R2 R3 R4: four pages tracked, three accesses to set 0 fan out
        acc(mk(28'hF4, 10, 0), 2'b00, WB, 0, 14);
        acc(40'h00000F1000, 2'b00, WB, 0, 14);
        acc(40'h00000F2008, 2'b01, WB, 0, 14);
        base = hs_cnt;
        acc(40'h00000F3004, 2'b00, WB, 0, 14);
        drained("R3 example burst");
        chk("R3 example burst size", 40'(hs_cnt - base), 40'd4);

        // R6 R2: ignored memory types and kinds do not advance the counter
        acc(mk(28'hF1, 20, 3), 2'b00, WB, 0, 14);
        acc(mk(28'hF1, 20, 9), 2'b01, WB, 0, 14);
        base = hs_cnt;
        acc(mk(28'hF1, 20, 1), 2'b00, 3'b100, 0, 14);
        acc(mk(28'hF1, 20, 2), 2'b00, 3'b101, 0, 14);
        acc(mk(28'hF1, 20, 2), 2'b00, 3'b000, 0, 14);
        acc(mk(28'hF1, 20, 2), 2'b10, WB, 0, 14);
        acc(mk(28'hF1, 20, 2), 2'b11, WB, 0, 14);
        chk("R6 non-write-back and other kinds ignored", 40'(hs_cnt - base), 40'd0);
        acc(mk(28'hF1, 20, 63), 2'b00, WB, 0, 14);
        chk("R2 third counted access triggers", 40'(hs_cnt - base), 40'd4);
        drained("R2 burst");

        // R5: written page neither counts nor is prefetched
        acc(mk(28'hF2, 30, 0), 2'b00, WB, 1, 14);
        base = hs_cnt;
        for (int i = 0; i < 3; i++) acc(mk(28'hF2, 31, i), 2'b00, WB, 0, 14);
        chk("R5 written page does not count", 40'(hs_cnt - base), 40'd0);
        for (int i = 0; i < 3; i++) acc(mk(28'hF1, 31, i), 2'b00, WB, 0, 14);
        chk("R5 written page excluded", 40'(hs_cnt - base), 40'd3);
        drained("R5 burst");

        // R4: a fifth page replaces the least recently touched entry
        for (int i = 0; i < 3; i++) acc(mk(28'hF5, 41, 0), 2'b00, WB, 0, 14);
        drained("R4 replacement burst");
        checks++;
        if (exp_a[qt-3] !== mk(28'hF5, 42, 0)) fail_line("R4 LRU victim entry 0", exp_a[qt-3], mk(28'hF5, 42, 0));

        // R7: last set of the page yields nothing
        base = hs_cnt;
        for (int i = 0; i < 3; i++) acc(mk(28'hF1, 63, 5), 2'b00, WB, 0, 14);
        chk("R7 no prefetch past page end", 40'(hs_cnt - base), 40'd0);

        // R10: flush clears table; same-cycle access ignored
        flush_with(mk(28'hF1, 50, 0));
        base = hs_cnt;
        acc(mk(28'hF6, 50, 0), 2'b00, WB, 0, 14);
        acc(mk(28'hF7, 50, 0), 2'b00, WB, 0, 14);
        acc(mk(28'hF6, 50, 0), 2'b00, WB, 0, 14);
        chk("R10 flush empties table", 40'(hs_cnt - base), 40'd2);
        base = hs_cnt;
        for (int i = 0; i < 3; i++) acc(mk(28'hF2, 52, 0), 2'b00, WB, 0, 14);
        chk("R10 flush clears written flag", 40'(hs_cnt - base), 40'd3);
        drained("R10 bursts");

        // R9: no free fill buffer drops the burst, no retry later
        fb_free = 0; drop_fb = 1;
        base = hs_cnt;
        for (int i = 0; i < 3; i++) acc(mk(28'hF6, 12, 0), 2'b00, WB, 0, 14);
        fb_free = 10; drop_fb = 0;
        repeat (10) @(negedge clk);
        chk("R9 dropped without retry", 40'(hs_cnt - base), 40'd0);
        for (int i = 0; i < 3; i++) acc(mk(28'hF6, 12, 0), 2'b00, WB, 0, 14);
        chk("R9 later trigger served", 40'(hs_cnt - base), 40'd3);

        // R8: fence holds the burst back
        fence_busy = 1; seen_valid = 0;
        for (int i = 0; i < 3; i++) acc(mk(28'hF7, 13, 0), 2'b00, WB, 0, 14);
        chk("R8 no request during fence", 40'(seen_valid), 40'd0);
        fence_busy = 0;
        repeat (14) @(negedge clk);
        drained("R8 burst after fence");

        // R11: hold under back-pressure, overlapping trigger discarded
        pf_ready = 0;
        base = hs_cnt;
        for (int i = 0; i < 3; i++) acc(mk(28'hF7, 14, 0), 2'b00, WB, 0, 6);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 valid held", 40'(pf_valid), 40'd1);
            chk("R11 address held", pf_addr, exp_a[qh]);
        end
        suppress = 1;
        for (int i = 0; i < 3; i++) acc(mk(28'hF6, 15, 0), 2'b00, WB, 0, 2);
        suppress = 0;
        pf_ready = 1;
        repeat (20) @(negedge clk);
        chk("R11 only first burst issued", 40'(hs_cnt - base), 40'd3);
        drained("R11 drain");

        // Sweep every set with churning pages (R2 R3 R4 R7)
        flush_with(mk(28'h0, 0, 0));
        for (int s = 0; s < 64; s++) begin
            acc(mk(28'h300 + 28'(s % 5), s, s), 2'(s % 2), WB, 0, 14);
            acc(mk(28'h300 + 28'((s + 2) % 5), s, 63 - s), 2'b01, WB, 0, 14);
            acc(mk(28'h300 + 28'(s % 5), s, 7), 2'b00, WB, 0, 14);
            drained("R3 sweep");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule